// File: doc/BRIEF.md
# Pended Interrupt Controller with Priority

This block sits between a set of peripheral interrupt request lines and a processor core. Each line drives a pending bit that latches the request. The request is remembered after the line drops, and repeated pulses merge into one request. A linear arbiter compares every line that is pending and not active. It picks the request with the smallest priority number, and on a tie the lowest line wins. It offers that request to the core when the request is strictly more urgent than the priority the core is running at and the global mask is clear.

When the core strobes handler start, the offered line loses its pending bit and becomes active. A line that is active cannot be offered again until the core signals an exception return carrying that line's exception number. A simple register port lets software do four things: set a pending bit, clear a pending bit, write an 8-bit priority field of which only the upper bits are kept, or move the vector table base. The offered request comes with its exception number (16 plus the line index) and the handler vector address. The address is the table base plus four times the exception number.

Top module: `irq_pend_ctrl`

## Requirements
- R1: A high level on `irq_req[i]` sets pending bit `pend_q[i]` at the next clock edge. The bit stays set after the line goes low, until the handler starts or software clears it.
- R2: `handler_start` while `take_req` is 1 clears the pending bit of the offered line and sets its active bit `act_q[i]` at the same edge. From that edge on, `take_req` no longer offers that line.
- R3: An active line is never offered. Its active bit is cleared only by `exc_return` with `ret_num` equal to 16+i. The line is offered again one cycle after that clearing edge if it is pending.
- R4: A line still held high when its active bit clears becomes pending again at the next edge. A rising edge on the line during the handler also re-pends it. Several pulses before service give a single request, and a pulse that starts in the same cycle as its own handler start merges into the request being taken.
- R5: With `reg_we`=1, `reg_op`=0 sets and `reg_op`=1 clears the pending bit of line `reg_idx`. A clear cancels a request that has not been taken. When a software clear and a hardware set land in the same cycle, the clear wins.
- R6: A smaller priority number is more urgent. A request is offered only when its 8-bit priority is strictly less than `run_prio`.
- R7: `reg_op`=2 writes `reg_wdata[7:0]` as the priority of line `reg_idx`, keeping only the upper PRIO_BITS bits. `rd_prio` shows the priority of line `reg_idx` one cycle later, with the low 8-PRIO_BITS bits read as zero. With PRIO_BITS=3, writing 0x3F reads back 0x20.
- R8: Among eligible requests of equal priority the lowest line index wins. `take_num` = 16 + line index.
- R9: `reg_op`=3 loads the table base from `reg_wdata`, with the low ALIGN_W = clog2(NUM_IRQ+16)+2 bits forced to zero. `take_vec` = base + 4*`take_num`.
- R10: While `gmask` is 1, `take_req` is 0. The mask does not stop lines from becoming pending.
- R11: `take_req`, `take_num` and `take_vec` are registered and follow the pending state one cycle later. Synchronous reset clears all pending and active bits, all priorities, the base and `take_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | NUM_IRQ | Raw interrupt request lines |
| handler_start | input | 1 | Core starts the offered handler |
| exc_return | input | 1 | Core leaves a handler |
| ret_num | input | EXC_W | Exception number of the handler being left |
| run_prio | input | 8 | Current running priority |
| gmask | input | 1 | Global mask for configurable-priority requests |
| reg_we | input | 1 | Register port write strobe |
| reg_op | input | 2 | 0 set pending, 1 clear pending, 2 write priority, 3 write base |
| reg_idx | input | IDX_W | Line index for writes and priority readback |
| reg_wdata | input | ADDR_W | Write data |
| take_req | output | 1 | A request is offered to the core |
| take_num | output | EXC_W | Exception number of the offered request |
| take_vec | output | ADDR_W | Handler vector address |
| pend_q | output | NUM_IRQ | Pending bits |
| act_q | output | NUM_IRQ | Active bits |
| rd_prio | output | 8 | Priority readback of line reg_idx |

## Verification
A handler start and a new rising edge on the same line can arrive in one cycle. The rule is that the new edge merges into the request being taken rather than pending the line again. The bench provokes this by raising the line in the very cycle it strobes `handler_start`. After that edge it expects the pending bit at 0 and the active bit at 1, and the pending bit stays 0 while the line remains high. A second collision is an exception return on a line whose request is still held. There the bench expects the active bit to fall at the return edge and the pending bit to rise one edge later.

// File: rtl/irq_pend_pkg.sv
package irq_pend_pkg;
  typedef enum logic [1:0] {
    OP_PEND_SET = 2'd0,
    OP_PEND_CLR = 2'd1,
    OP_PRIO_WR  = 2'd2,
    OP_BASE_WR  = 2'd3
  } reg_op_e;

  localparam int EXC_FIRST = 16;
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int NUM_IRQ = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_IRQ-1:0] irq_req,
  input  logic [NUM_IRQ-1:0] start_vec,
  input  logic [NUM_IRQ-1:0] ret_vec,
  input  logic [NUM_IRQ-1:0] sw_set,
  input  logic [NUM_IRQ-1:0] sw_clr,
  output logic [NUM_IRQ-1:0] pend_q,
  output logic [NUM_IRQ-1:0] act_q
);
  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
    logic p_r, a_r, prev_r, hw_set;

    // level while idle, or a fresh rising edge while the handler runs
    assign hw_set = irq_req[i] & ~start_vec[i] & (~a_r | ~prev_r);

    always_ff @(posedge clk) begin
      if (rst) begin
        p_r    <= 1'b0;
        a_r    <= 1'b0;
        prev_r <= 1'b0;
      end else begin
        prev_r <= irq_req[i];
        if (start_vec[i])             p_r <= 1'b0;
        else if (sw_clr[i])           p_r <= 1'b0;
        else if (hw_set || sw_set[i]) p_r <= 1'b1;
        if (start_vec[i])             a_r <= 1'b1;
        else if (ret_vec[i])          a_r <= 1'b0;
      end
    end

    assign pend_q[i] = p_r;
    assign act_q[i]  = a_r;

    // R1: pending is sticky
    p_pend_sticky_r1: assert property (@(posedge clk) disable iff (rst)
      p_r && !start_vec[i] && !sw_clr[i] |=> p_r);
    // R2: start moves the line from pending to active
    p_start_moves_r2: assert property (@(posedge clk) disable iff (rst)
      start_vec[i] |=> a_r && !p_r);
    // R3: active holds until its return
    p_active_hold_r3: assert property (@(posedge clk) disable iff (rst)
      a_r && !ret_vec[i] && !start_vec[i] |=> a_r);
  end
endmodule

// File: rtl/irq_prio_regs.sv
module irq_prio_regs #(
  parameter int NUM_IRQ   = 8,
  parameter int PRIO_BITS = 3,
  parameter int IDX_W     = 3
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              wr_en,
  input  logic [IDX_W-1:0]                  wr_idx,
  input  logic [7:0]                        wr_data,
  input  logic [IDX_W-1:0]                  rd_idx,
  output logic [NUM_IRQ-1:0][PRIO_BITS-1:0] prio_flat,
  output logic [7:0]                        rd_prio
);
  localparam int DROP = 8 - PRIO_BITS;

  logic [PRIO_BITS-1:0] prio_r [NUM_IRQ];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_IRQ; i++) prio_r[i] <= '0;
      rd_prio <= '0;
    end else begin
      if (wr_en) prio_r[wr_idx] <= wr_data[7:DROP];
      rd_prio <= 8'(prio_r[rd_idx]) << DROP;
    end
  end

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_flat
    assign prio_flat[i] = prio_r[i];
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int NUM_IRQ   = 8,
  parameter int PRIO_BITS = 3,
  parameter int IDX_W     = 3
) (
  input  logic [NUM_IRQ-1:0]                elig,
  input  logic [NUM_IRQ-1:0][PRIO_BITS-1:0] prio_flat,
  output logic                              found,
  output logic [IDX_W-1:0]                  win_idx,
  output logic [7:0]                        win_prio
);
  logic [PRIO_BITS-1:0] best_p;

  // scan from line 0 upward; strict compare keeps the lowest index on ties
  always_comb begin
    found   = 1'b0;
    win_idx = '0;
    best_p  = '1;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (elig[i] && (!found || prio_flat[i] < best_p)) begin
        found   = 1'b1;
        win_idx = IDX_W'(i);
        best_p  = prio_flat[i];
      end
    end
    win_prio = 8'(best_p) << (8 - PRIO_BITS);
  end
endmodule

// File: rtl/irq_pend_ctrl.sv
module irq_pend_ctrl
  import irq_pend_pkg::*;
#(
  parameter int NUM_IRQ   = 8,
  parameter int PRIO_BITS = 3,
  parameter int ADDR_W    = 32,
  localparam int IDX_W    = $clog2(NUM_IRQ),
  localparam int EXC_W    = $clog2(NUM_IRQ + EXC_FIRST)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_IRQ-1:0] irq_req,
  input  logic               handler_start,
  input  logic               exc_return,
  input  logic [EXC_W-1:0]   ret_num,
  input  logic [7:0]         run_prio,
  input  logic               gmask,
  input  logic               reg_we,
  input  logic [1:0]         reg_op,
  input  logic [IDX_W-1:0]   reg_idx,
  input  logic [ADDR_W-1:0]  reg_wdata,
  output logic               take_req,
  output logic [EXC_W-1:0]   take_num,
  output logic [ADDR_W-1:0]  take_vec,
  output logic [NUM_IRQ-1:0] pend_q,
  output logic [NUM_IRQ-1:0] act_q,
  output logic [7:0]         rd_prio
);
  localparam int ALIGN_W = EXC_W + 2;

  reg_op_e op;
  assign op = reg_op_e'(reg_op);

  logic [NUM_IRQ-1:0] start_vec, ret_vec, sw_set, sw_clr, elig;
  logic [IDX_W-1:0]   take_idx_q, win_idx;
  logic [ADDR_W-1:0]  base_q;
  logic [NUM_IRQ-1:0][PRIO_BITS-1:0] prio_flat;
  logic               found;
  logic [7:0]         win_prio;
  logic [EXC_W-1:0]   cand_num, ret_off;

  assign ret_off = ret_num - EXC_W'(EXC_FIRST);

  always_comb begin
    for (int i = 0; i < NUM_IRQ; i++) begin
      start_vec[i] = handler_start && take_req && (take_idx_q == IDX_W'(i));
      ret_vec[i]   = exc_return && (ret_num >= EXC_W'(EXC_FIRST)) && (ret_off == EXC_W'(i));
      sw_set[i]    = reg_we && (op == OP_PEND_SET) && (reg_idx == IDX_W'(i));
      sw_clr[i]    = reg_we && (op == OP_PEND_CLR) && (reg_idx == IDX_W'(i));
    end
  end

  irq_pend_bank #(.NUM_IRQ(NUM_IRQ)) u_bank (
    .clk(clk), .rst(rst), .irq_req(irq_req), .start_vec(start_vec),
    .ret_vec(ret_vec), .sw_set(sw_set), .sw_clr(sw_clr),
    .pend_q(pend_q), .act_q(act_q)
  );

  irq_prio_regs #(.NUM_IRQ(NUM_IRQ), .PRIO_BITS(PRIO_BITS), .IDX_W(IDX_W)) u_prio (
    .clk(clk), .rst(rst), .wr_en(reg_we && (op == OP_PRIO_WR)), .wr_idx(reg_idx),
    .wr_data(reg_wdata[7:0]), .rd_idx(reg_idx), .prio_flat(prio_flat), .rd_prio(rd_prio)
  );

  // the line being started this cycle is already out of the race
  assign elig = pend_q & ~act_q & ~start_vec;

  irq_arbiter #(.NUM_IRQ(NUM_IRQ), .PRIO_BITS(PRIO_BITS), .IDX_W(IDX_W)) u_arb (
    .elig(elig), .prio_flat(prio_flat), .found(found),
    .win_idx(win_idx), .win_prio(win_prio)
  );

  assign cand_num = EXC_W'(EXC_FIRST) + EXC_W'(win_idx);

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q     <= '0;
      take_req   <= 1'b0;
      take_num   <= '0;
      take_vec   <= '0;
      take_idx_q <= '0;
    end else begin
      if (reg_we && op == OP_BASE_WR)
        base_q <= {reg_wdata[ADDR_W-1:ALIGN_W], ALIGN_W'(0)};
      take_req   <= found && (win_prio < run_prio) && !gmask;
      take_idx_q <= win_idx;
      take_num   <= cand_num;
      take_vec   <= base_q + (ADDR_W'(cand_num) << 2);
    end
  end

  // R10: masked cycles never lead to an offer
  p_mask_blocks_r10: assert property (@(posedge clk) disable iff (rst)
    gmask |=> !take_req);
  // R3: an offered line is never already active
  p_offer_not_active_r3: assert property (@(posedge clk) disable iff (rst)
    take_req |-> !act_q[take_idx_q]);
  // R9: offered vectors are word aligned and numbered from 16
  p_vec_aligned_r9: assert property (@(posedge clk) disable iff (rst)
    take_req |-> take_vec[1:0] == 2'b00 && take_num >= EXC_W'(EXC_FIRST));
  // R7: unstored priority bits read as zero
  p_prio_low_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_prio & ~(8'hFF << (8 - PRIO_BITS))) == 8'h00);
endmodule

// File: tb/irq_pend_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_pend_ctrl_tb_top;
  localparam int NI = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst, handler_start, exc_return, gmask, reg_we;
  logic [NI-1:0] irq_req;
  logic [4:0]    ret_num;
  logic [7:0]    run_prio;
  logic [1:0]    reg_op;
  logic [2:0]    reg_idx;
  logic [31:0]   reg_wdata;
  logic          take_req;
  logic [4:0]    take_num;
  logic [31:0]   take_vec;
  logic [NI-1:0] pend_q, act_q;
  logic [7:0]    rd_prio;

  irq_pend_ctrl #(.NUM_IRQ(NI), .PRIO_BITS(3), .ADDR_W(32)) dut_i (
    .clk(clk), .rst(rst), .irq_req(irq_req), .handler_start(handler_start),
    .exc_return(exc_return), .ret_num(ret_num), .run_prio(run_prio), .gmask(gmask),
    .reg_we(reg_we), .reg_op(reg_op), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
    .take_req(take_req), .take_num(take_num), .take_vec(take_vec),
    .pend_q(pend_q), .act_q(act_q), .rd_prio(rd_prio)
  );

  int n_chk = 0, n_fail = 0;
  localparam logic [31:0] BASE_EXP = 32'h1234_5600;

  typedef struct packed {
    logic [7:0] mask;
    logic [7:0] rp;
    logic       req;
    logic [4:0] num;
  } vec_t;

  localparam vec_t TBL [9] = '{
    '{8'h01, 8'hFF, 1'b1, 5'd16},
    '{8'h06, 8'hFF, 1'b1, 5'd17},
    '{8'h49, 8'hFF, 1'b1, 5'd22},
    '{8'h49, 8'h00, 1'b0, 5'd0},
    '{8'h08, 8'h80, 1'b0, 5'd0},
    '{8'h08, 8'h81, 1'b1, 5'd19},
    '{8'hB0, 8'hFF, 1'b1, 5'd20},
    '{8'hA0, 8'hB0, 1'b1, 5'd23},
    '{8'h00, 8'hFF, 1'b0, 5'd0}
  };

  localparam logic [7:0] PRIO_SET [8] = '{8'h60, 8'h3F, 8'h20, 8'h80, 8'h40, 8'hE0, 8'h00, 8'hA0};

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic sw(input logic [1:0] op, input int idx, input logic [31:0] d);
    reg_we = 1'b1; reg_op = op; reg_idx = 3'(idx); reg_wdata = d;
    tick();
    reg_we = 1'b0;
  endtask

  task automatic pulse(input logic [NI-1:0] m);
    irq_req = m;
    tick();
    irq_req = '0;
  endtask

  task automatic clear_all();
    for (int i = 0; i < NI; i++) sw(2'd1, i, 0);
    tick();
  endtask

  task automatic start_h();
    handler_start = 1'b1; tick(); handler_start = 1'b0;
  endtask

  task automatic ret_h(input logic [4:0] n);
    exc_return = 1'b1; ret_num = n; tick(); exc_return = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    rst = 1'b1; irq_req = '0; handler_start = 0; exc_return = 0; ret_num = '0;
    run_prio = 8'hFF; gmask = 0; reg_we = 0; reg_op = '0; reg_idx = '0; reg_wdata = '0;
    repeat (3) tick();
    rst = 1'b0;
    // R11 reset state
    chk("R11 take_req after reset", 32'(take_req), 0);
    chk("R11 pend after reset", 32'(pend_q), 0);
    chk("R11 act after reset", 32'(act_q), 0);
    chk("R11 rd_prio after reset", 32'(rd_prio), 0);

    for (int i = 0; i < NI; i++) sw(2'd2, i, 32'(PRIO_SET[i]));
    sw(2'd3, 0, 32'h1234_5678);
    reg_idx = 3'd1; tick();
    chk("R7 low bits dropped on line 1", 32'(rd_prio), 32'h20);
    reg_idx = 3'd5; tick();
    chk("R7 readback line 5", 32'(rd_prio), 32'hE0);

    // arbitration table: R6 R8 R9
    for (int k = 0; k < 9; k++) begin
      run_prio = TBL[k].rp;
      pulse(TBL[k].mask);
      tick();
      chk($sformatf("R6 R8 vector %0d take_req", k), 32'(take_req), 32'(TBL[k].req));
      if (TBL[k].req) begin
        chk($sformatf("R8 vector %0d take_num", k), 32'(take_num), 32'(TBL[k].num));
        chk($sformatf("R9 vector %0d take_vec", k), take_vec, BASE_EXP + 32'(TBL[k].num) * 4);
      end
      clear_all();
    end
    run_prio = 8'hFF;

    // R1 sticky pending
    pulse(8'h01);
    chk("R1 pending after line drop", 32'(pend_q), 32'h01);
    tick();
    chk("R1 serviced after line drop", 32'(take_req), 1);
    chk("R11 take_num line 0", 32'(take_num), 16);
    // R2 start
    start_h();
    chk("R2 pending cleared", 32'(pend_q[0]), 0);
    chk("R2 active set", 32'(act_q[0]), 1);
    chk("R2 offer withdrawn", 32'(take_req), 0);
    // R3 no retake while active
    pulse(8'h01);
    chk("R4 re-pend during handler", 32'(pend_q[0]), 1);
    tick();
    chk("R3 not offered while active", 32'(take_req), 0);
    ret_h(5'd16);
    chk("R3 active cleared by return", 32'(act_q[0]), 0);
    tick();
    chk("R3 offered again after return", 32'(take_req), 1);
    start_h(); ret_h(5'd16); tick();
    chk("R3 cleanup", 32'(pend_q | act_q), 0);

    // R4 held line re-pends on exit
    irq_req = 8'h04; tick(); tick();
    chk("R4 held line offered", 32'(take_num), 18);
    start_h();
    chk("R4 no pend while held and active", 32'(pend_q[2]), 0);
    tick();
    chk("R4 still no pend while active", 32'(pend_q[2]), 0);
    ret_h(5'd18);
    chk("R4 active cleared", 32'(act_q[2]), 0);
    tick();
    chk("R4 re-pended after exit", 32'(pend_q[2]), 1);
    irq_req = '0; tick();
    start_h(); ret_h(5'd18); tick();
    chk("R4 cleanup", 32'(pend_q | act_q), 0);

    // R4 pulses collapse
    run_prio = 8'h00;
    pulse(8'h10); tick(); pulse(8'h10); tick(); pulse(8'h10);
    chk("R4 pulses pend once", 32'(pend_q), 32'h10);
    chk("R6 blocked by run_prio 0", 32'(take_req), 0);
    run_prio = 8'hFF; tick();
    chk("R4 collapsed request offered", 32'(take_num), 20);
    start_h();
    chk("R4 single request consumed", 32'(pend_q), 0);
    ret_h(5'd20); tick();
    chk("R4 no second service", 32'(take_req), 0);

    // R5 / R10 software pend with mask
    gmask = 1'b1;
    sw(2'd0, 3, 0);
    chk("R10 pends under mask", 32'(pend_q), 32'h08);
    tick();
    chk("R10 no offer under mask", 32'(take_req), 0);
    sw(2'd1, 3, 0);
    chk("R5 software cancel", 32'(pend_q), 0);
    gmask = 1'b0; tick(); tick();
    chk("R5 cancelled stays quiet", 32'(take_req), 0);
    sw(2'd0, 3, 0); tick();
    chk("R5 software raise offered", 32'(take_num), 19);
    chk("R5 software raise take_req", 32'(take_req), 1);
    // R5 clear beats a hardware set in the same cycle
    irq_req = 8'h40; reg_we = 1'b1; reg_op = 2'd1; reg_idx = 3'd6; tick();
    reg_we = 1'b0; irq_req = '0;
    chk("R5 clear wins over hw set", 32'(pend_q[6]), 0);
    sw(2'd1, 3, 0); tick();

    // collision: start and new edge on same line
    sw(2'd0, 5, 0); tick();
    chk("R8 line 5 offered", 32'(take_num), 21);
    irq_req = 8'h20; handler_start = 1'b1; tick(); handler_start = 1'b0;
    chk("R4 edge merged into start", 32'(pend_q[5]), 0);
    chk("R2 line 5 active", 32'(act_q[5]), 1);
    tick();
    chk("R4 held edge no extra pend", 32'(pend_q[5]), 0);
    irq_req = '0;
    ret_h(5'd21); tick();
    chk("R3 nothing left after collision", 32'({take_req, pend_q}), 0);

    summary();
    $finish;
  end
endmodule